// File: doc/BRIEF.md
# Flag Interrupt Controller

This block collects a vector of internal status conditions into a flag register and reduces them to one registered interrupt line for the host. The condition inputs come from elsewhere in the chip: FIFO level thresholds, command completion, error detectors. Each condition sets its flag. A host port reads and writes the control and status registers. Per flag it can enable the interrupt, choose edge or level triggering, and choose whether the flag follows its condition back down or holds until software clears it.

Software clears status bits by writing ones. A bit written as zero is untouched. When hardware sets a bit in the same cycle that software clears it, the set takes effect. In edge mode a separate pending bit records each rising edge of the flag, so a short condition still raises the interrupt after the flag itself has dropped. The host port reads combinationally from the current register state. Writes take effect at the next clock edge.

Top module: `flag_irq_ctrl`

## Requirements
- R1: While reset is asserted, every register reads zero and `irq` is low.
- R2: A flag whose condition input is high at a clock edge reads 1 after that edge. Writing 1 to a bit at address 0 (flags) clears that flag.
- R3: A flag whose hold bit (address 3) is 0 clears when its condition is low at an edge. A flag whose hold bit is 1 stays set until software clears it.
- R4: When a condition is high in the same cycle that software writes 1 to clear the matching flag or pending bit, the bit is set after the edge.
- R5: The mask (address 1), trigger-mode (address 2, 1 = edge, 0 = level) and hold (address 3) registers read back the value last written.
- R6: For a flag in edge mode, a 0-to-1 change of the flag sets its pending bit (address 4). The pending bit stays set after the flag drops, until a write of 1 to that bit clears it.
- R7: A level-mode flag that is unmasked drives the interrupt for as long as the flag is set.
- R8: A flag or pending bit whose mask bit is 0 never raises `irq`.
- R9: `irq` is the OR of all unmasked contributions (pending bits for edge flags, flags for level flags), registered one clock after the state that produces it.
- R10: Address 5 reads the current unmasked contributions, one bit per flag. It is read-only.
- R11: Writing 0 bits to the flag or pending register changes nothing. Addresses 6 and 7 read zero. Writes to addresses 5 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond | input | NF | Event condition per flag |
| wr_en | input | 1 | Host write strobe |
| addr | input | 3 | Register address |
| wr_data | input | NF | Host write data |
| rd_data | output | NF | Register read data, combinational |
| irq | output | 1 | Host interrupt, registered |

## Verification
A corrupted flag, pending or configuration bit shows up at `rd_data` as soon as the host addresses that register, in the cycle after the bad update. If the corrupted bit is unmasked, `irq` is also wrong one clock later. A reference model in the bench is compared against `irq` and the addressed register on every clock. Because of that, a bad clear priority or a lost edge is caught in the first cycle it matters, and the long pseudo-random phase sweeps through addresses so that hidden state is read back often.

// File: rtl/flag_irq_ctrl.sv
module flag_irq_ctrl #(
  parameter int NF = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] cond,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [NF-1:0] wr_data,
  output logic [NF-1:0] rd_data,
  output logic          irq
);
  localparam logic [2:0] A_FLAG  = 3'd0;
  localparam logic [2:0] A_MASK  = 3'd1;
  localparam logic [2:0] A_TRIG  = 3'd2;
  localparam logic [2:0] A_HOLD  = 3'd3;
  localparam logic [2:0] A_PEND  = 3'd4;
  localparam logic [2:0] A_CAUSE = 3'd5;

  logic [NF-1:0] flag_q, mask_q, trig_q, hold_q, pend_q;
  logic [NF-1:0] flag_nx, pend_nx, rise, clr_flag, clr_pend, contrib;

  assign clr_flag = (wr_en && addr == A_FLAG) ? wr_data : '0;
  assign clr_pend = (wr_en && addr == A_PEND) ? wr_data : '0;

  assign flag_nx = cond | (flag_q & hold_q & ~clr_flag);
  assign rise    = flag_nx & ~flag_q;
  assign pend_nx = (rise & trig_q) | (pend_q & ~clr_pend);
  assign contrib = mask_q & ((trig_q & pend_q) | (~trig_q & flag_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      pend_q <= '0;
      mask_q <= '0;
      trig_q <= '0;
      hold_q <= '0;
      irq    <= 1'b0;
    end else begin
      flag_q <= flag_nx;
      pend_q <= pend_nx;
      irq    <= |contrib;
      if (wr_en && addr == A_MASK) mask_q <= wr_data;
      if (wr_en && addr == A_TRIG) trig_q <= wr_data;
      if (wr_en && addr == A_HOLD) hold_q <= wr_data;
    end
  end

  always_comb begin
    case (addr)
      A_FLAG:  rd_data = flag_q;
      A_MASK:  rd_data = mask_q;
      A_TRIG:  rd_data = trig_q;
      A_HOLD:  rd_data = hold_q;
      A_PEND:  rd_data = pend_q;
      A_CAUSE: rd_data = contrib;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/flag_irq_ctrl_chk.sv
module flag_irq_ctrl_chk #(
  parameter int NF = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NF-1:0] cond,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic [NF-1:0] flag,
  input logic [NF-1:0] mask,
  input logic [NF-1:0] trig,
  input logic [NF-1:0] hold,
  input logic [NF-1:0] pend,
  input logic          irq
);
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cond != '0) |=> ((flag & $past(cond)) == $past(cond))); // R4

  AST_HOLD_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd0) |=> ((flag & $past(flag & hold)) == $past(flag & hold))); // R3

  AST_PEND_FROM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (((pend & ~$past(pend)) & ~(flag & ~$past(flag))) == '0)); // R6

  AST_LEVEL_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask & flag & ~trig) != '0) |=> irq); // R7

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask & ((trig & pend) | (~trig & flag))) == '0) |=> !irq); // R8
endmodule

bind flag_irq_ctrl flag_irq_ctrl_chk #(.NF(NF)) u_chk (
  .clk(clk), .rst_n(rst_n), .cond(cond), .wr_en(wr_en), .addr(addr),
  .flag(flag_q), .mask(mask_q), .trig(trig_q), .hold(hold_q),
  .pend(pend_q), .irq(irq)
);

// File: tb/flag_irq_ctrl_test.sv
module flag_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cond = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  bit [15:0] m_flag, m_mask, m_trig, m_hold, m_pend;
  bit        m_irq;

  always #2 clk = ~clk;

  flag_irq_ctrl #(.NF(16)) uut (
    .clk(clk), .rst_n(rst_n), .cond(cond), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  function automatic bit [15:0] m_cause();
    bit [15:0] r = '0;
    for (int i = 0; i < 16; i++)
      if (m_mask[i] && (m_trig[i] ? m_pend[i] : m_flag[i])) r[i] = 1'b1;
    return r;
  endfunction

  function automatic bit [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_flag;
      3'd1: return m_mask;
      3'd2: return m_trig;
      3'd3: return m_hold;
      3'd4: return m_pend;
      3'd5: return m_cause();
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1, 3'd2, 3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] c, input logic w, input logic [2:0] a, input logic [15:0] d);
    bit [15:0] nf, np;
    bit ni;
    @(negedge clk);
    cond = c; wr_en = w; addr = a; wr_data = d;
    ni = (m_cause() != '0);
    for (int i = 0; i < 16; i++) begin
      nf[i] = c[i] | (m_flag[i] & m_hold[i] & !(w && a == 3'd0 && d[i]));
      np[i] = (nf[i] & !m_flag[i] & m_trig[i]) | (m_pend[i] & !(w && a == 3'd4 && d[i]));
    end
    @(posedge clk);
    m_flag = nf; m_pend = np; m_irq = ni;
    if (w && a == 3'd1) m_mask = d;
    if (w && a == 3'd2) m_trig = d;
    if (w && a == 3'd3) m_hold = d;
    #1;
    check("R9", {15'd0, irq}, {15'd0, m_irq});
    check(tag_of(a), rd_data, m_read(a));
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    bit [31:0] lfsr = 32'hACE1_1234;
    m_flag = '0; m_mask = '0; m_trig = '0; m_hold = '0; m_pend = '0; m_irq = 0;
    repeat (3) @(posedge clk);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      check("R1", rd_data, 16'h0000);
    end
    check("R1", {15'd0, irq}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    step(0, 1, 3'd1, 16'h0005);
    step(0, 1, 3'd2, 16'h0004);
    step(0, 1, 3'd3, 16'h0001);
    step(0, 0, 3'd1, 0); check("R5", rd_data, 16'h0005);
    step(0, 0, 3'd2, 0); check("R5", rd_data, 16'h0004);
    step(0, 0, 3'd3, 0); check("R5", rd_data, 16'h0001);

    step(16'h0003, 0, 3'd0, 0); check("R2", rd_data, 16'h0003);
    check("R9", {15'd0, irq}, 16'h0000);
    step(0, 0, 3'd0, 0); check("R3", rd_data, 16'h0001);
    check("R7", {15'd0, irq}, 16'h0001);
    step(0, 0, 3'd5, 0); check("R10", rd_data, 16'h0001);

    step(0, 1, 3'd0, 16'h0001);
    step(16'h0002, 0, 3'd0, 0);
    step(16'h0002, 0, 3'd0, 0); check("R8", {15'd0, irq}, 16'h0000);

    step(16'h0001, 1, 3'd0, 16'h0001); check("R4", rd_data, 16'h0001);
    step(0, 1, 3'd0, 16'h0001);
    step(0, 0, 3'd0, 0); check("R2", rd_data, 16'h0000);

    step(16'h0004, 0, 3'd4, 0); check("R6", rd_data, 16'h0004);
    step(0, 0, 3'd4, 0); check("R6", rd_data, 16'h0004);
    check("R9", {15'd0, irq}, 16'h0001);
    step(0, 0, 3'd4, 0); check("R6", {15'd0, irq}, 16'h0001);

    step(0, 1, 3'd4, 16'h0000); check("R11", rd_data, 16'h0004);
    step(0, 1, 3'd7, 16'hFFFF); check("R11", rd_data, 16'h0000);
    step(0, 0, 3'd1, 0); check("R11", rd_data, 16'h0005);

    step(16'h0004, 1, 3'd4, 16'h0004); check("R4", rd_data, 16'h0004);
    step(0, 1, 3'd4, 16'h0004); check("R6", rd_data, 16'h0000);
    step(0, 0, 3'd4, 0); check("R9", {15'd0, irq}, 16'h0000);

    for (int n = 0; n < 3000; n++) begin
      logic [15:0] c, d;
      logic w;
      logic [2:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      c = lfsr[15:0] & lfsr[31:16] & {lfsr[7:0], lfsr[15:8]};
      w = (lfsr[3:2] == 2'b00);
      a = lfsr[26:24];
      d = {lfsr[12:0], lfsr[31:29]};
      step(c, w, a, d);
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule